// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the host end of a three- or four-wire serial link to an 8-bit sampling converter. A one-cycle start request opens a transfer. The block pulls the chip select low and waits out a setup interval. It then produces the serial clock from the system clock, where each half period lasts a fixed number of system cycles. When the transfer completes, it returns chip select high. The serial clock rests low whenever chip select is high.

A mode input sets the transfer length. The short mode runs 12 serial clocks and sends no command. The long mode runs 16 serial clocks and opens with a four-bit command: a start marker, the single-ended/differential choice, the channel/polarity choice, and one filler bit. In both modes the converter returns null bits first and the result after them, most significant bit first. The last eight rising edges of the frame carry the result. Chip select rises on the falling edge that follows the last data bit.

The result leaves through a valid/ready output. `res_valid` rises together with a one-cycle `done` pulse. `res_valid` and `res_data` then hold until a cycle in which `res_ready` is high. While a result waits unaccepted, start requests are ignored, so a sink that holds `res_ready` low stalls the link rather than losing data. `busy` is a plain status pin. It stays high from the accepted start until the chip-select high interval has elapsed.

Top module: `sadc_reader`

## Requirements
- R1: After reset, `adc_cs_n` is 1 and `adc_sclk`, `adc_mosi`, `busy`, `done` and `res_valid` are 0. Whenever `adc_cs_n` is 1, `adc_sclk` is 0.
- R2: A start request is accepted when the block is idle and no result is pending. Chip select falls on the next clock. `busy` is high for as long as chip select is low.
- R3: The first rising serial-clock edge comes `CS_SETUP_CYC` system cycles after chip select falls.
- R4: Every high phase of the serial clock lasts `HALF_DIV` system cycles. Every low phase between two rising edges also lasts `HALF_DIV` system cycles.
- R5: A frame has exactly 12 rising edges when `long_mode` is 0 and exactly 16 when `long_mode` is 1.
- R6: In long mode, `adc_mosi` holds these values before rising edges 1 to 4: 1, then `single_end`, then `odd_sel`, then 0. It is 0 at every later edge. It is 0 throughout short mode. It changes only when chip select falls or the serial clock falls.
- R7: With a frame of N rising edges, the bits sampled on edges N-7 through N form `res_data`, with the bit from edge N-7 in position 7 and the bit from edge N in position 0. Earlier bits are discarded.
- R8: Chip select rises on the falling edge that follows rising edge N. `done` and `res_valid` rise in that same cycle.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `res_data` hold and start requests are ignored. Once the result is accepted, `res_valid` falls.
- R10: A start request that arrives while `busy` is high is ignored. It opens no second frame.
- R11: Between two frames, chip select stays high for at least `CS_GAP_CYC` system cycles.
- R12: `done` is high for exactly one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one transfer |
| long_mode | input | 1 | 1: 16-clock frame with command; 0: 12-clock frame without command |
| single_end | input | 1 | Command bit 2: single-ended (1) or differential (0) |
| odd_sel | input | 1 | Command bit 3: channel or polarity choice |
| busy | output | 1 | Transfer or chip-select high interval in progress |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_mosi | output | 1 | Command line to the converter |
| adc_miso | input | 1 | Data line from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Sink accepts the result |
| res_data | output | 8 | Converted byte |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench builds the block with `HALF_DIV` = 2, `CS_SETUP_CYC` = 3 and `CS_GAP_CYC` = 2. With these values a full frame is about 70 system cycles. That makes it practical to return every one of the 256 result codes in both frame lengths, with the two command flags taken from the low bits of the code so all four command patterns recur. A converter model in the bench answers on the serial clock. Each frame's setup interval, phase lengths, edge count and command bits are measured against arithmetic from the parameters. Directed runs then cover a start request in mid-frame, a stalled sink, and back-to-back starts that expose the chip-select high interval.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_W        = 8;
  localparam int CMD_LEN      = 4;
  localparam int EDGE_W       = 5;
  localparam int FRAME_SHORT  = 12;
  localparam int FRAME_LONG   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } sadc_state_e;

  function automatic logic [EDGE_W-1:0] frame_edges(input logic long_sel);
    return long_sel ? EDGE_W'(FRAME_LONG) : EDGE_W'(FRAME_SHORT);
  endfunction
endpackage

// File: rtl/sadc_div.sv
module sadc_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // phase counter never passes the half-period limit
  assert_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // an idle divider restarts from zero
  assert_div_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/sadc_cmd.sv
module sadc_cmd
  import sadc_pkg::*;
(
  input  logic              long_sel,
  input  logic              single_sel,
  input  logic              odd_sel,
  input  logic [EDGE_W-1:0] idx,
  output logic              bit_out
);
  logic [CMD_LEN-1:0] word;

  // index 0 leads: start marker, mode, channel, filler
  assign word = {1'b0, odd_sel, single_sel, 1'b1};

  always_comb begin
    bit_out = 1'b0;
    if (long_sel && (idx < EDGE_W'(CMD_LEN))) begin
      bit_out = word[idx[$clog2(CMD_LEN)-1:0]];
    end
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         load,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (shift_en) begin
        sr <= {sr[W-2:0], bit_in};
      end
      if (load) begin
        out_data  <= sr;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // a waiting result is held untouched
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // no new result lands on an unaccepted one
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
  // no shifting once a frame has been closed
  assert_no_shift_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift_en);
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int HALF_DIV     = 4,
  parameter int CS_SETUP_CYC = 2,
  parameter int CS_GAP_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             long_mode,
  input  logic             single_end,
  input  logic             odd_sel,
  output logic             busy,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_mosi,
  input  logic             adc_miso,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic             done
);
  localparam int WMAX = (CS_SETUP_CYC > CS_GAP_CYC) ? CS_SETUP_CYC : CS_GAP_CYC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam logic [WW-1:0] SETUP_LAST = WW'(CS_SETUP_CYC - 1);
  localparam logic [WW-1:0] GAP_LAST   = WW'(CS_GAP_CYC - 1);

  sadc_state_e       state;
  logic [WW-1:0]     wcnt;
  logic [EDGE_W-1:0] ecnt;
  logic              lmode_q, sgl_q, odd_q;
  logic              cs_n_q, sclk_q, mosi_q, done_q;

  logic              tick, run, pending, accept;
  logic              rise_now, last_fall;
  logic [EDGE_W-1:0] flen, first_data, enext;
  logic              cmd_long, cmd_sgl, cmd_odd, cmd_bit;
  logic [EDGE_W-1:0] cmd_idx;
  logic              shift_en;

  assign run        = (state == ST_HIGH) || (state == ST_LOW);
  assign pending    = res_valid && !res_ready;
  assign accept     = (state == ST_IDLE) && start && !pending;
  assign flen       = frame_edges(lmode_q);
  assign first_data = flen - EDGE_W'(RES_W - 1);
  assign enext      = ecnt + EDGE_W'(1);
  assign rise_now   = ((state == ST_SETUP) && (wcnt == SETUP_LAST)) ||
                      ((state == ST_LOW) && tick);
  assign last_fall  = (state == ST_HIGH) && tick && (ecnt == flen);
  assign shift_en   = rise_now && (enext >= first_data);

  assign cmd_long = (state == ST_IDLE) ? long_mode  : lmode_q;
  assign cmd_sgl  = (state == ST_IDLE) ? single_end : sgl_q;
  assign cmd_odd  = (state == ST_IDLE) ? odd_sel    : odd_q;
  assign cmd_idx  = (state == ST_IDLE) ? '0 : ecnt;

  sadc_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  sadc_cmd u_cmd (
    .long_sel  (cmd_long),
    .single_sel(cmd_sgl),
    .odd_sel   (cmd_odd),
    .idx       (cmd_idx),
    .bit_out   (cmd_bit)
  );

  sadc_capture #(.W(RES_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (adc_miso),
    .load     (last_fall),
    .out_ready(res_ready),
    .out_valid(res_valid),
    .out_data (res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      ecnt    <= '0;
      lmode_q <= 1'b0;
      sgl_q   <= 1'b0;
      odd_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            lmode_q <= long_mode;
            sgl_q   <= single_end;
            odd_q   <= odd_sel;
            cs_n_q  <= 1'b0;
            mosi_q  <= cmd_bit;
            wcnt    <= '0;
            ecnt    <= '0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (wcnt == SETUP_LAST) begin
            sclk_q <= 1'b1;
            ecnt   <= enext;
            state  <= ST_HIGH;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (ecnt == flen) begin
              cs_n_q <= 1'b1;
              mosi_q <= 1'b0;
              done_q <= 1'b1;
              wcnt   <= '0;
              state  <= ST_GAP;
            end else begin
              mosi_q <= cmd_bit;
              state  <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk_q <= 1'b1;
            ecnt   <= enext;
            state  <= ST_HIGH;
          end
        end
        ST_GAP: begin
          if (wcnt == GAP_LAST) begin
            state <= ST_IDLE;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign adc_cs_n = cs_n_q;
  assign adc_sclk = sclk_q;
  assign adc_mosi = mosi_q;
  assign done     = done_q;

  // clock rests low while deselected
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  // selection implies busy
  assert_busy_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);
  // command line is steady through each high phase
  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_mosi));
  // edge count never exceeds the frame length
  assert_edge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= flen);
  // the done pulse coincides with deselect
  assert_done_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (adc_cs_n && !$past(adc_cs_n) && res_valid));
  // done lasts one cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // a request while busy does not restart the frame
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_cs_n) |=> (!adc_cs_n || done));
endmodule

// File: tb/sadc_reader_bench.sv
module sadc_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int GAP   = 2;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       long_mode = 1'b0;
  logic       single_end = 1'b0;
  logic       odd_sel = 1'b0;
  logic       res_ready = 1'b1;
  logic       adc_miso = 1'b0;
  logic       busy, adc_cs_n, adc_sclk, adc_mosi, res_valid, done;
  logic [7:0] res_data;

  int checks = 0;
  int fails  = 0;

  // converter model and monitor state
  logic       cur_mode = 1'b0;
  logic       cur_sgl = 1'b0;
  logic       cur_odd = 1'b0;
  logic [7:0] dev_val = 8'h00;
  logic       prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_done = 1'b0;
  int redges = 0, setup_len = 0, hi_len = 0, lo_len = 0, gap_len = 0;
  int phase_bad = 0, cmd_bad = 0, mosi_bad = 0, idle_bad = 0, done_bad = 0;
  int frames_started = 0, done_seen = 0, last_gap = 0;
  int min_gap = 1000000;
  bit have_prev = 1'b0;
  logic [7:0] cap_data = 8'h00;

  sadc_reader #(
    .HALF_DIV    (HALF),
    .CS_SETUP_CYC(SETUP),
    .CS_GAP_CYC  (GAP)
  ) u_sadc_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .long_mode (long_mode),
    .single_end(single_end),
    .odd_sel   (odd_sel),
    .busy      (busy),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_mosi  (adc_mosi),
    .adc_miso  (adc_miso),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .done      (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_cmd(input int k);
    if (!cur_mode) return 1'b0;
    case (k)
      1: return 1'b1;
      2: return cur_sgl;
      3: return cur_odd;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int frame_n();
    return cur_mode ? 16 : 12;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor and converter model, sampled away from the active edge
  always @(negedge clk) begin
    bit cs_fell, cs_rose, sc_rise, sc_fall;
    int e, first;
    if (rst_n) begin
      cs_fell = prev_cs && !adc_cs_n;
      cs_rose = !prev_cs && adc_cs_n;
      sc_rise = !prev_sclk && adc_sclk;
      sc_fall = prev_sclk && !adc_sclk;
      if (cs_fell) begin
        if (have_prev) begin
          last_gap = gap_len;
          if (gap_len < min_gap) min_gap = gap_len;
        end
        redges = 0; setup_len = 0; hi_len = 0; lo_len = 0;
        phase_bad = 0; cmd_bad = 0; mosi_bad = 0;
        frames_started++;
        adc_miso = 1'b0;
      end
      if (adc_mosi !== prev_mosi && !sc_fall && !cs_fell) mosi_bad++;
      if (!adc_cs_n) begin
        if (sc_rise) begin
          if (redges > 0 && lo_len != HALF) phase_bad++;
          redges++;
          hi_len = 1;
          if (adc_mosi !== exp_cmd(redges)) cmd_bad++;
        end else if (adc_sclk) begin
          hi_len++;
        end else if (sc_fall) begin
          if (hi_len != HALF) phase_bad++;
          lo_len = 1;
          e = redges + 1;
          first = frame_n() - 7;
          if (e >= first && e <= frame_n()) adc_miso = dev_val[7 - (e - first)];
          else adc_miso = 1'b0;
        end else if (redges == 0) begin
          setup_len++;
        end else begin
          lo_len++;
        end
      end else begin
        if (adc_sclk) idle_bad++;
        if (cs_rose) begin
          if (sc_fall && hi_len != HALF) phase_bad++;
          gap_len = 1;
          have_prev = 1'b1;
          adc_miso = 1'b0;
        end else begin
          gap_len++;
        end
      end
      if (done) begin
        done_seen++;
        if (!(cs_rose && res_valid)) done_bad++;
        if (prev_done) done_bad++;
        cap_data = res_data;
      end
      prev_cs = adc_cs_n;
      prev_sclk = adc_sclk;
      prev_mosi = adc_mosi;
      prev_done = done;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic wait_done(input int d0, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      if (done_seen != d0) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_frame(input logic m, input logic s, input logic o,
                           input logic [7:0] v, input bit extra);
    int d0, f0;
    bit seen;
    wait_idle();
    cur_mode = m; cur_sgl = s; cur_odd = o; dev_val = v;
    long_mode = m; single_end = s; odd_sel = o;
    d0 = done_seen; f0 = frames_started;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (12) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(d0, seen);
    chk(seen, "R2 frame completes", int'(seen), 1);
    chk(redges == frame_n(), "R5 rising edges per frame", redges, frame_n());
    chk(setup_len == SETUP, "R3 chip-select setup cycles", setup_len, SETUP);
    chk(phase_bad == 0, "R4 serial clock phase length", phase_bad, 0);
    chk(cmd_bad == 0 && mosi_bad == 0, "R6 command line", cmd_bad + mosi_bad, 0);
    chk(cap_data == v, "R7 assembled result", int'(cap_data), int'(v));
    chk(done_bad == 0, "R8 done with deselect", done_bad, 0);
    if (extra) begin
      repeat (30) @(negedge clk);
      chk(frames_started == f0 + 1, "R10 start while busy ignored",
          frames_started - f0, 1);
    end
  endtask

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    int d0, f0;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1 cs_n after reset", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0 && adc_mosi == 1'b0, "R1 sclk/mosi after reset",
        int'(adc_sclk) + int'(adc_mosi), 0);
    chk(busy == 1'b0 && done == 1'b0 && res_valid == 1'b0, "R1 status after reset",
        int'(busy) + int'(done) + int'(res_valid), 0);

    // sweep: every code, both frame lengths, command flags from the code
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        run_frame(m[0], v[0], v[1], v[7:0], 1'b0);
      end
    end

    // R10 second request in the middle of a frame
    run_frame(1'b1, 1'b0, 1'b1, 8'h3C, 1'b1);
    run_frame(1'b0, 1'b1, 1'b1, 8'hC3, 1'b1);

    // R9 stalled sink
    res_ready = 1'b0;
    run_frame(1'b1, 1'b1, 1'b0, 8'hA5, 1'b0);
    repeat (20) @(negedge clk);
    chk(res_valid == 1'b1, "R9 valid held", int'(res_valid), 1);
    chk(res_data == 8'hA5, "R9 data held", int'(res_data), 'hA5);
    f0 = frames_started;
    start = 1'b1;
    repeat (6) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(frames_started == f0 && adc_cs_n == 1'b1, "R9 start ignored while pending",
        frames_started - f0, 0);
    res_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 valid drops on accept", int'(res_valid), 0);

    // R11 back-to-back starts
    wait_idle();
    cur_mode = 1'b0; dev_val = 8'h5A;
    long_mode = 1'b0;
    d0 = done_seen;
    start = 1'b1;
    wait_done(d0, seen);
    d0 = done_seen;
    wait_done(d0, seen);
    @(negedge clk);
    start = 1'b0;
    chk(seen, "R11 second back-to-back frame", int'(seen), 1);
    chk(last_gap >= GAP, "R11 chip-select high interval", last_gap, GAP);
    chk(min_gap >= GAP, "R11 minimum high interval", min_gap, GAP);
    chk(cap_data == 8'h5A, "R7 back-to-back result", int'(cap_data), 'h5A);
    wait_idle();
    repeat (5) @(negedge clk);

    // R1 and R12 over the whole run
    chk(idle_bad == 0, "R1 clock low while deselected", idle_bad, 0);
    chk(done_bad == 0, "R12 single-cycle done", done_bad, 0);
    chk(done_seen == frames_started, "R12 one done per frame", done_seen, frames_started);

    summary();
    $finish;
  end
endmodule